// File: doc/BRIEF.md
# Event Counter Snapshot Controller

This block keeps a bank of event counters for one line port. Each counter counts single-cycle event pulses. A snapshot copies the live value of every counter into that counter's holding register and clears the counter in the same clock edge. The holding registers feed the readout logic, and they stay stable between snapshots.

A mode input selects what triggers a snapshot. In port mode, the trigger is a rising edge on the port's update-request bit. In global mode, the trigger is a pulse on a shared global strobe. The trigger source that is not selected is ignored.

A done flag completes a level handshake with software. Software raises the request, waits for the flag, then lowers the request. Lowering the request clears the flag. The event pulses, the control bits and the held counts are plain wires. The block has no valid/ready stream: events cannot be refused, and the held counts are static registers, so the block never applies back-pressure.

Top module: `perf_snap_ctrl`

## Requirements
- R1: Each lane i counts the cycles in which `evt_i[i]` is high, one count per cycle.
- R2: A counter that reaches 2^CNT_W-1 stays at that value. It does not wrap.
- R3: When `upd_mode_i`=0, a cycle in which `upd_req_i` is high after being low in the previous cycle is a snapshot. At that clock edge, lane i's held count (`held_o[i*CNT_W +: CNT_W]`) takes the counter value and the counter clears.
- R4: Holding `upd_req_i` high does not cause another snapshot. Only the low-to-high change does.
- R5: An event in the snapshot cycle is not part of the held value. It becomes the first count of the new interval.
- R6: `done_o` rises at the clock edge one cycle after the snapshot edge, and at no other time.
- R7: `done_o` stays high until a cycle in which `upd_req_i` is low after being high. At that cycle's edge `done_o` returns to 0, in either mode.
- R8: When `upd_mode_i`=1, any cycle with `glb_upd_i` high is a snapshot, with the same effect as R3.
- R9: A `glb_upd_i` pulse when `upd_mode_i`=0, or a rising `upd_req_i` when `upd_mode_i`=1, changes neither the held counts nor `done_o`, and does not clear any counter.
- R10: After reset, every counter and held count is 0 and `done_o` is 0.
- R11: Held counts change only at snapshot edges.
- R12: If the clearing edge of R7 falls on the same edge at which `done_o` is being set, `done_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CNT | Event pulses, one per lane |
| upd_mode_i | input | 1 | Trigger source: 0 port request bit, 1 global strobe |
| upd_req_i | input | 1 | Port update-request level from software |
| glb_upd_i | input | 1 | Global update strobe |
| held_o | output | NUM_CNT*CNT_W | Held counts, lane i at bits i*CNT_W +: CNT_W |
| done_o | output | 1 | Snapshot-done flag |

## Verification
The checker runs on every cycle and watches the handshake timing. It checks that the flag rises exactly one edge after a trigger and never without one. It checks that the flag holds until the request falls, and that a falling request clears it unless a set lands on the same edge. It also checks that the held counts stay frozen outside trigger cycles, even when the trigger source that is not selected pulses.

Only the bench scenarios can show the values loaded into the holding registers. These include counts gathered over several event patterns, saturation at the counter limit, an event that lands in the snapshot cycle, and counts that carry over past an ignored trigger.

// File: rtl/perf_snap_pkg.sv
package perf_snap_pkg;

  // Selects which input acts as the snapshot trigger.
  typedef enum logic {
    SRC_PORT   = 1'b0,
    SRC_GLOBAL = 1'b1
  } upd_src_e;

  // Counters narrower than this cannot hold a count in the snapshot cycle.
  localparam int MIN_CNT_W = 2;

endpackage

// File: rtl/psc_trigger.sv
// Turns the port request level and the global strobe into a single snapshot
// pulse. Also detects the falling edge of the request, which clears the flag.
module psc_trigger
  import perf_snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic req_i,
  input  logic glb_i,
  output logic snap_o,
  output logic req_fall_o
);

  upd_src_e src;
  logic     req_q;
  logic     req_rise;

  assign src = upd_src_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_i;
    end
  end

  assign req_rise   = req_i & ~req_q;
  assign req_fall_o = ~req_i & req_q;

  always_comb begin
    unique case (src)
      SRC_GLOBAL: snap_o = glb_i;
      default:    snap_o = req_rise;
    endcase
  end

endmodule

// File: rtl/psc_lane.sv
// One counter and its holding register.
module psc_lane #(
  parameter int CNT_W    = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] held_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] held_q;

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + CNT_ONE;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else if (snap_i) begin
      // An event in the snapshot cycle starts the new interval.
      held_q <= cnt_q;
      cnt_q  <= evt_i ? CNT_ONE : '0;
    end else if (evt_i) begin
      cnt_q  <= cnt_inc;
    end
  end

  assign held_o = held_q;

endmodule

// File: rtl/psc_status.sv
// Done flag: set one edge after the snapshot, cleared by the request falling.
// A set wins over a clear that lands on the same edge.
module psc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic snap_i,
  input  logic clr_i,
  output logic done_o
);

  logic snap_q;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      snap_q <= snap_i;
      if (snap_q) begin
        done_q <= 1'b1;
      end else if (clr_i) begin
        done_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/perf_snap_ctrl.sv
module perf_snap_ctrl #(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       evt_i,
  input  logic                     upd_mode_i,
  input  logic                     upd_req_i,
  input  logic                     glb_upd_i,
  output logic [NUM_CNT*CNT_W-1:0] held_o,
  output logic                     done_o
);

  localparam int HELD_W = NUM_CNT * CNT_W;

  logic snap;
  logic req_fall;

  psc_trigger u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (upd_mode_i),
    .req_i      (upd_req_i),
    .glb_i      (glb_upd_i),
    .snap_o     (snap),
    .req_fall_o (req_fall)
  );

  logic [HELD_W-1:0] held_flat;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    psc_lane #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[i]),
      .snap_i (snap),
      .held_o (held_flat[i*CNT_W +: CNT_W])
    );
  end

  assign held_o = held_flat;

  psc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .snap_i (snap),
    .clr_i  (req_fall),
    .done_o (done_o)
  );

endmodule

// File: rtl/perf_snap_ctrl_chk.sv
module perf_snap_ctrl_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     upd_mode_i,
  input logic                     upd_req_i,
  input logic                     glb_upd_i,
  input logic [NUM_CNT*CNT_W-1:0] held_o,
  input logic                     done_o
);

  logic req_prev;
  logic trig_d;
  logic req_up;
  logic req_down;
  logic trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      trig_d   <= 1'b0;
    end else begin
      req_prev <= upd_req_i;
      trig_d   <= trig;
    end
  end

  assign req_up   = upd_req_i & ~req_prev;
  assign req_down = ~upd_req_i & req_prev;
  assign trig     = upd_mode_i ? glb_upd_i : req_up;

  // R6
  done_after_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_d |=> done_o);

  // R6
  done_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(trig_d));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !req_down) |=> done_o);

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_down && !trig_d) |=> !done_o);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_down && trig_d) |=> done_o);

  // R11
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(held_o));

  // R9
  port_ignores_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_mode_i && glb_upd_i && !req_up) |=> $stable(held_o));

  // R9
  glb_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode_i && req_up && !glb_upd_i) |=> $stable(held_o));

endmodule

bind perf_snap_ctrl perf_snap_ctrl_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_mode_i (upd_mode_i),
  .upd_req_i  (upd_req_i),
  .glb_upd_i  (glb_upd_i),
  .held_o     (held_o),
  .done_o     (done_o)
);

// File: tb/perf_snap_ctrl_bench.sv
`timescale 1ns/1ps
module perf_snap_ctrl_bench;

  localparam int N = 4;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         mode = 1'b0;
  logic         req = 1'b0;
  logic         glb = 1'b0;
  logic [N*W-1:0] held;
  logic         done;

  always #2.5 clk = ~clk;

  perf_snap_ctrl #(.NUM_CNT(N), .CNT_W(W), .SATURATE(1'b1)) u_perf_snap_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .upd_mode_i (mode),
    .upd_req_i  (req),
    .glb_upd_i  (glb),
    .held_o     (held),
    .done_o     (done)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Scoreboard queues and bench model
  logic [N*W-1:0] exp_q[$];
  string          tag_q[$];
  int             cnt_m[N];
  logic [N*W-1:0] held_m = '0;
  logic           req_prev_m = 1'b0;
  logic           done_prev = 1'b0;

  task automatic chk(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pack_model();
    logic [N*W-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = cnt_m[i][W-1:0];
    return v;
  endfunction

  // Driver: applies one cycle of stimulus and pushes expected snapshots.
  task automatic step(input logic [N-1:0] e, input logic r, input logic g);
    logic trig;
    @(negedge clk);
    evt = e; req = r; glb = g;
    trig = mode ? g : (r && !req_prev_m);
    if (trig) begin
      held_m = pack_model();
      exp_q.push_back(held_m);
      tag_q.push_back(mode ? "R8" : "R3/R5");
      for (int i = 0; i < N; i++) cnt_m[i] = e[i] ? 1 : 0;
    end else begin
      for (int i = 0; i < N; i++)
        if (e[i] && cnt_m[i] < MAXV) cnt_m[i]++;
    end
    req_prev_m = r;
    @(posedge clk); #1;
  endtask

  // Monitor: every rising done flag must match a pending snapshot.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && done && !done_prev) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6 done rose with no pending snapshot actual=1 expected=0");
        end else begin
          chk(tag_q.pop_front(), held, exp_q.pop_front());
        end
      end
      done_prev = done;
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    for (int i = 0; i < N; i++) cnt_m[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 held after reset", held, '0);
    chk("R10 done after reset", {{(N*W-1){1'b0}}, done}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1: several event patterns in port mode
    repeat (3) step(4'b0001, 0, 0);
    repeat (2) step(4'b0110, 0, 0);
    step(4'b1111, 0, 0);
    // R3 R5: snapshot with an event in the same cycle
    step(4'b1000, 1, 0);
    chk("R3 held at snapshot edge", held, held_m);
    chk("R6 done still low at snapshot edge", {{(N*W-1){1'b0}}, done}, '0);
    step(4'b0000, 1, 0);
    chk("R6 done one edge later", {{(N*W-1){1'b0}}, done}, 1);
    // R4: level held high, more events, no retrigger
    repeat (2) step(4'b0001, 1, 0);
    chk("R4 held unchanged while request high", held, held_m);
    chk("R7 done held while request high", {{(N*W-1){1'b0}}, done}, 1);
    step(4'b0000, 0, 0);
    chk("R7 done cleared by falling request", {{(N*W-1){1'b0}}, done}, '0);
    // R9: global strobe ignored in port mode
    step(4'b0010, 0, 1);
    chk("R9 held unchanged by strobe in port mode", held, held_m);
    chk("R9 done unchanged by strobe in port mode", {{(N*W-1){1'b0}}, done}, '0);
    // R2: saturation of lane 2
    repeat (20) step(4'b0100, 0, 0);
    step(4'b0000, 1, 0);
    chk("R2 saturated lane", {{(N*W-W){1'b0}}, held[2*W +: W]}, MAXV);
    step(4'b0000, 1, 0);
    step(4'b0000, 0, 0);

    // R8: global mode
    @(negedge clk); mode = 1'b1;
    step(4'b0011, 0, 0);
    step(4'b0001, 1, 0);
    chk("R9 rising request ignored in global mode", held, held_m);
    step(4'b0001, 1, 1);
    chk("R8 held at strobe edge", held, held_m);
    step(4'b0000, 1, 0);
    chk("R8 done after strobe", {{(N*W-1){1'b0}}, done}, 1);
    step(4'b0000, 0, 0);
    chk("R7 done cleared in global mode", {{(N*W-1){1'b0}}, done}, '0);
    // R12: falling request on the edge where done is set
    step(4'b0100, 1, 0);
    step(4'b0100, 1, 1);
    step(4'b0000, 0, 0);
    chk("R12 set wins over clear", {{(N*W-1){1'b0}}, done}, 1);
    step(4'b0000, 1, 0);
    step(4'b0000, 0, 0);
    chk("R7 later falling request clears", {{(N*W-1){1'b0}}, done}, '0);
    chk("R11 held stable after handshakes", held, held_m);

    repeat (3) step(4'b0000, 0, 0);
    chk("R6 all snapshots reported", exp_q.size(), 0);
    report();
  end

endmodule